// File: doc/BRIEF.md
# Automatic Record Level Controller

This block steers the gain of a stereo record front end. It watches 24-bit two's complement samples from the left and right channels. From them it keeps one shared gain offset. The offset is subtracted from two programmable initial gain codes, and the two results drive the front-end amplifiers. Each gain code counts 0.5 dB steps from 0 (0 dB) to 48 (24 dB). Because both channels lose the same offset, the dB difference between them is preserved.

**Attack.** When a sample is loud enough, the offset grows by one step. The block then skips a programmable number of samples before it tests again.

**Recovery.** Three recovery policies take the gain back towards its initial value:
- none (the gain stays reduced);
- normal (one step back after every quiet interval);
- limited (recovery gives up for good after a programmable number of intervals that were not quiet).

**Settings.** The settings are copied into shadow registers on every clock while the controller is disabled. They are frozen while it is enabled.

**State machine.** The controller has four states:
- `ST_OFF` (disabled);
- `ST_WATCH` (testing samples for attack only);
- `ST_HOLD` (waiting out the attack time);
- `ST_REC` (counting a recovery interval and testing for attack).

**Transitions.**
- Enable moves `ST_OFF` to `ST_WATCH`. Disable returns any state to `ST_OFF`. A reset write returns any enabled state to `ST_WATCH`.
- An attack sample moves `ST_WATCH` or `ST_REC` to `ST_HOLD`.
- When the hold count expires, `ST_HOLD` goes to `ST_REC` if recovery is allowed, and to `ST_WATCH` otherwise.
- `ST_REC` falls back to `ST_WATCH` when the offset reaches zero or the limited-recovery lock is set.

Top module: `alc_rec_level`

## Requirements
- R1: After reset and while disabled, offset is 0, the flags are low, and each gain output equals the initial gain captured on the previous clock. A captured initial gain above 48 is clamped to 48.
- R2: A sample's level is its two's complement magnitude, so 24'h800000 has level 8388608. A level counts as over a threshold only when it is strictly greater than that threshold.
- R3: In `ST_WATCH` or `ST_REC`, a valid sample that triggers attack raises the offset by one at the next clock edge and sets `attacking`. The next 2^atk_time valid samples are not tested, and the sample after them is tested again.
- R4: With `both_ch`=0, either channel over the attack threshold triggers attack. With `both_ch`=1, both channels must be over it in the same sample.
- R5: The offset never exceeds the smaller captured initial gain, so no gain goes below 0. An attack taken at that bound changes no gain.
- R6: `rec_mode` 2'b00 and 2'b11 select no recovery. The offset then stays until a reset write or a disable/enable cycle clears it.
- R7: `rec_mode` 2'b01 selects normal recovery, where an interval is 2^rec_time valid samples. After an interval in which no sample went over the recovery threshold on either channel, the offset drops by one. After any other interval it holds. Recovery ends when the offset reaches 0.
- R8: `rec_mode` 2'b10 selects limited recovery, with quiet intervals handled as in R7. Each interval that was not quiet increments a counter. When the counter reaches `lim_max` (at least 1), `locked` is set and recovery stops. A new attack clears both the counter and `locked`.
- R9: While `alc_en` is 1, changes on the gain, threshold, time, mode and limit inputs have no effect on any output.
- R10: A `clr_wr` pulse while enabled sets the offset to 0, clears `locked` and the flags, and returns to `ST_WATCH`.
- R11: `gain_l` and `gain_r` equal their captured initial gains minus the offset, and never exceed them.
- R12: `recovering` is high exactly in `ST_REC`, and `attacking` is high exactly in `ST_HOLD`. Cycles with `smp_vld` low advance no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Sample strobe |
| smp_l | input | 24 | Left sample, two's complement |
| smp_r | input | 24 | Right sample, two's complement |
| atk_thr | input | 24 | Attack threshold (unsigned level) |
| rec_thr | input | 24 | Recovery threshold (unsigned level) |
| init_gain_l | input | 6 | Left initial and maximum gain code |
| init_gain_r | input | 6 | Right initial and maximum gain code |
| atk_time | input | 3 | Attack wait, 2^code samples |
| rec_time | input | 3 | Recovery interval, 2^code samples |
| rec_mode | input | 2 | 00/11 none, 01 normal, 10 limited |
| both_ch | input | 1 | 1: both channels must exceed the attack threshold |
| lim_max | input | 4 | Limited-recovery interval limit |
| alc_en | input | 1 | Controller enable |
| clr_wr | input | 1 | Reset write strobe |
| gain_l | output | 6 | Left gain code |
| gain_r | output | 6 | Right gain code |
| attacking | output | 1 | Attack wait in progress |
| recovering | output | 1 | Recovery interval in progress |
| locked | output | 1 | Limited recovery has given up |
| offset | output | 6 | Current shared offset |

## Verification
The assertions assume that `rst_n` is asserted before the first edge and that `alc_en` and `clr_wr` are driven to known values from time zero. They also assume `lim_max` is at least 1 whenever limited recovery runs. The stimulus changes settings only while the controller is disabled, except in the one scenario that deliberately writes them while it is enabled. It keeps every threshold below full scale. It holds `alc_en` low for at least one clock between reconfigurations, so that the shadow copy has settled before enable rises.

// File: rtl/alc_pkg.sv
package alc_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_HOLD  = 2'd2,
        ST_REC   = 2'd3
    } alc_state_t;

    typedef enum logic [1:0] {
        RM_NONE     = 2'b00,
        RM_NORMAL   = 2'b01,
        RM_LIMITED  = 2'b10,
        RM_NONE_ALT = 2'b11
    } rec_mode_t;

endpackage

// File: rtl/alc_peak_cmp.sv
module alc_peak_cmp #(
    parameter int DW = 24
) (
    input  logic [DW-1:0] smp,
    input  logic [DW-1:0] atk_thr,
    input  logic [DW-1:0] rec_thr,
    output logic          over_atk,
    output logic          over_rec
);

    logic [DW-1:0] level;

    always_comb begin
        if (smp[DW-1]) begin
            level = ~smp + {{(DW-1){1'b0}}, 1'b1};
        end else begin
            level = smp;
        end
        over_atk = level > atk_thr;
        over_rec = level > rec_thr;
    end

endmodule

// File: rtl/alc_smp_timer.sv
module alc_smp_timer #(
    parameter int TCW = 3,
    localparam int CNTW = 1 << TCW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [TCW-1:0] code,
    input  logic           tick,
    output logic           last
);

    logic [CNTW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNTW'(1) << code;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - CNTW'(1);
        end
    end

    assign last = (cnt == CNTW'(1));

endmodule

// File: rtl/alc_fsm.sv
module alc_fsm
    import alc_pkg::*;
#(
    parameter int GW  = 6,
    parameter int TCW = 3,
    parameter int LCW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           clr,
    input  logic           smp_vld,
    input  logic           atk_hit,
    input  logic           rec_hit,
    input  rec_mode_t      mode,
    input  logic [TCW-1:0] atk_code,
    input  logic [TCW-1:0] rec_code,
    input  logic [LCW-1:0] lim_max,
    input  logic [GW-1:0]  off_max,
    input  logic           tmr_last,
    output logic           tmr_load,
    output logic [TCW-1:0] tmr_code,
    output logic [GW-1:0]  offset,
    output logic           locked,
    output logic           attacking,
    output logic           recovering
);

    alc_state_t     state, nxt_state;
    logic [LCW-1:0] lim_cnt;
    logic           dirty;
    logic           off_inc, off_dec, lim_clr, lim_inc, lock_set;
    logic           dirty_clr, dirty_set, dirty_now, rec_on;

    assign rec_on = (mode == RM_NORMAL) || (mode == RM_LIMITED);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt_state;
        end
    end

    // next state and step decisions
    always_comb begin
        nxt_state = state;
        off_inc   = 1'b0;
        off_dec   = 1'b0;
        lim_clr   = 1'b0;
        lim_inc   = 1'b0;
        lock_set  = 1'b0;
        dirty_clr = 1'b0;
        dirty_set = 1'b0;
        tmr_load  = 1'b0;
        tmr_code  = atk_code;
        dirty_now = dirty | rec_hit;
        if (!en) begin
            nxt_state = ST_OFF;
        end else if (clr) begin
            nxt_state = ST_WATCH;
        end else begin
            unique case (state)
                ST_OFF: nxt_state = ST_WATCH;
                ST_WATCH, ST_REC: begin
                    if (smp_vld) begin
                        if (atk_hit) begin
                            off_inc   = (offset < off_max);
                            lim_clr   = 1'b1;
                            tmr_load  = 1'b1;
                            tmr_code  = atk_code;
                            nxt_state = ST_HOLD;
                        end else if (state == ST_REC) begin
                            if (tmr_last) begin
                                tmr_load  = 1'b1;
                                tmr_code  = rec_code;
                                dirty_clr = 1'b1;
                                if (!dirty_now) begin
                                    off_dec = 1'b1;
                                    if (offset == GW'(1)) nxt_state = ST_WATCH;
                                end else if (mode == RM_LIMITED) begin
                                    lim_inc = 1'b1;
                                    if (({1'b0, lim_cnt} + 1'b1) >= {1'b0, lim_max}) begin
                                        lock_set  = 1'b1;
                                        nxt_state = ST_WATCH;
                                    end
                                end
                            end else begin
                                dirty_set = rec_hit;
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    if (smp_vld && tmr_last) begin
                        if (rec_on && offset != '0 && !locked) begin
                            nxt_state = ST_REC;
                            tmr_load  = 1'b1;
                            tmr_code  = rec_code;
                            dirty_clr = 1'b1;
                        end else begin
                            nxt_state = ST_WATCH;
                        end
                    end
                end
            endcase
        end
    end

    // offset, interval and limit bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset  <= '0;
            lim_cnt <= '0;
            locked  <= 1'b0;
            dirty   <= 1'b0;
        end else if (!en || clr) begin
            offset  <= '0;
            lim_cnt <= '0;
            locked  <= 1'b0;
            dirty   <= 1'b0;
        end else begin
            if (off_inc) begin
                offset <= offset + GW'(1);
            end else if (off_dec) begin
                offset <= offset - GW'(1);
            end
            if (lim_clr) begin
                lim_cnt <= '0;
                locked  <= 1'b0;
            end else begin
                if (lim_inc)  lim_cnt <= lim_cnt + LCW'(1);
                if (lock_set) locked  <= 1'b1;
            end
            if (dirty_clr) begin
                dirty <= 1'b0;
            end else if (dirty_set) begin
                dirty <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        attacking  = (state == ST_HOLD);
        recovering = (state == ST_REC);
    end

    a_r3_step_of_one: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !$past(clr)) |->
        (offset == $past(offset) || offset == $past(offset) + GW'(1) || offset + GW'(1) == $past(offset)));

    a_r3_hold_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !$past(clr) && offset == $past(offset) + GW'(1)) |-> (state == ST_HOLD));

    a_r7_drop_only_in_rec: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !$past(clr) && offset < $past(offset)) |-> ($past(state) == ST_REC));

    a_r8_lock_stops_rec: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (state != ST_REC));

    a_r6_no_rec_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RM_NONE || mode == RM_NONE_ALT) |-> (state != ST_REC));

    a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr || !en) |=> (offset == '0 && !locked));

endmodule

// File: rtl/alc_rec_level.sv
module alc_rec_level
    import alc_pkg::*;
#(
    parameter int DW   = 24,
    parameter int GMAX = 48,
    parameter int TCW  = 3,
    parameter int LCW  = 4,
    localparam int GW  = $clog2(GMAX + 1),
    localparam int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_vld,
    input  logic [DW-1:0]  smp_l,
    input  logic [DW-1:0]  smp_r,
    input  logic [DW-1:0]  atk_thr,
    input  logic [DW-1:0]  rec_thr,
    input  logic [GW-1:0]  init_gain_l,
    input  logic [GW-1:0]  init_gain_r,
    input  logic [TCW-1:0] atk_time,
    input  logic [TCW-1:0] rec_time,
    input  logic [1:0]     rec_mode,
    input  logic           both_ch,
    input  logic [LCW-1:0] lim_max,
    input  logic           alc_en,
    input  logic           clr_wr,
    output logic [GW-1:0]  gain_l,
    output logic [GW-1:0]  gain_r,
    output logic           attacking,
    output logic           recovering,
    output logic           locked,
    output logic [GW-1:0]  offset
);

    localparam logic [GW-1:0] GCAP = GW'(GMAX);

    // shadow copy of the settings, frozen while enabled
    logic [GW-1:0]  sh_gl, sh_gr;
    logic [DW-1:0]  sh_atk, sh_rec;
    logic [TCW-1:0] sh_atk_t, sh_rec_t;
    rec_mode_t      sh_mode;
    logic           sh_both;
    logic [LCW-1:0] sh_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_gl    <= '0;
            sh_gr    <= '0;
            sh_atk   <= '0;
            sh_rec   <= '0;
            sh_atk_t <= '0;
            sh_rec_t <= '0;
            sh_mode  <= RM_NONE;
            sh_both  <= 1'b0;
            sh_lim   <= '0;
        end else if (!alc_en) begin
            sh_gl    <= (init_gain_l > GCAP) ? GCAP : init_gain_l;
            sh_gr    <= (init_gain_r > GCAP) ? GCAP : init_gain_r;
            sh_atk   <= atk_thr;
            sh_rec   <= rec_thr;
            sh_atk_t <= atk_time;
            sh_rec_t <= rec_time;
            sh_mode  <= rec_mode_t'(rec_mode);
            sh_both  <= both_ch;
            sh_lim   <= lim_max;
        end
    end

    // per-channel level detection
    logic [NCH-1:0][DW-1:0] smp_arr;
    logic [NCH-1:0]         over_atk, over_rec;

    assign smp_arr = {smp_r, smp_l};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        alc_peak_cmp #(.DW(DW)) u_cmp (
            .smp      (smp_arr[c]),
            .atk_thr  (sh_atk),
            .rec_thr  (sh_rec),
            .over_atk (over_atk[c]),
            .over_rec (over_rec[c])
        );
    end

    logic atk_hit, rec_hit;
    assign atk_hit = sh_both ? (&over_atk) : (|over_atk);
    assign rec_hit = |over_rec;

    // shared sample timer for attack wait and recovery interval
    logic           tmr_load, tmr_last;
    logic [TCW-1:0] tmr_code;

    alc_smp_timer #(.TCW(TCW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .code  (tmr_code),
        .tick  (smp_vld),
        .last  (tmr_last)
    );

    logic [GW-1:0] off_max;
    assign off_max = (sh_gl < sh_gr) ? sh_gl : sh_gr;

    alc_fsm #(.GW(GW), .TCW(TCW), .LCW(LCW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (alc_en),
        .clr        (clr_wr),
        .smp_vld    (smp_vld),
        .atk_hit    (atk_hit),
        .rec_hit    (rec_hit),
        .mode       (sh_mode),
        .atk_code   (sh_atk_t),
        .rec_code   (sh_rec_t),
        .lim_max    (sh_lim),
        .off_max    (off_max),
        .tmr_last   (tmr_last),
        .tmr_load   (tmr_load),
        .tmr_code   (tmr_code),
        .offset     (offset),
        .locked     (locked),
        .attacking  (attacking),
        .recovering (recovering)
    );

    assign gain_l = sh_gl - offset;
    assign gain_r = sh_gr - offset;

    a_r5_offset_bound: assert property (@(posedge clk) disable iff (!rst_n)
        offset <= off_max);

    a_r11_gain_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_l <= sh_gl) && (gain_r <= sh_gr));

endmodule

// File: tb/alc_rec_level_tb.sv
`timescale 1ns/1ps
module alc_rec_level_tb;

    localparam logic [23:0] QUIET  = 24'h001000;
    localparam logic [23:0] QUIETN = 24'hFFF000;
    localparam logic [23:0] LOUD   = 24'h500000;
    localparam logic [23:0] LOUDN  = 24'hB00000;
    localparam logic [23:0] MID    = 24'h200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [23:0] smp_l = '0, smp_r = '0;
    logic [23:0] atk_thr = '0, rec_thr = '0;
    logic [5:0]  init_gain_l = '0, init_gain_r = '0;
    logic [2:0]  atk_time = '0, rec_time = '0;
    logic [1:0]  rec_mode = '0;
    logic        both_ch = 1'b0;
    logic [3:0]  lim_max = '0;
    logic        alc_en = 1'b0, clr_wr = 1'b0;
    logic [5:0]  gain_l, gain_r, offset;
    logic        attacking, recovering, locked;

    always #5 clk = ~clk;

    alc_rec_level u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_l(smp_l), .smp_r(smp_r),
        .atk_thr(atk_thr), .rec_thr(rec_thr), .init_gain_l(init_gain_l),
        .init_gain_r(init_gain_r), .atk_time(atk_time), .rec_time(rec_time),
        .rec_mode(rec_mode), .both_ch(both_ch), .lim_max(lim_max), .alc_en(alc_en),
        .clr_wr(clr_wr), .gain_l(gain_l), .gain_r(gain_r), .attacking(attacking),
        .recovering(recovering), .locked(locked), .offset(offset)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string phase = "R1";
    bit    done = 0;

    // behavioural reference: 0 off, 1 watch, 2 hold, 3 recover
    int m_st, m_off, m_left, m_lim;
    bit m_lock, m_dirty;
    int s_gl, s_gr, s_atk, s_rec, s_at, s_rt, s_mode, s_lim;
    bit s_both;

    function automatic int level(logic [23:0] s);
        return s[23] ? (32'd16777216 - int'(s)) : int'(s);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_off = 0; m_left = 0; m_lim = 0; m_lock = 0; m_dirty = 0;
            s_gl = 0; s_gr = 0; s_atk = 0; s_rec = 0; s_at = 0; s_rt = 0;
            s_mode = 0; s_lim = 0; s_both = 0;
        end else begin
            bit ah, rh, d;
            int lo;
            ah = s_both ? (level(smp_l) > s_atk && level(smp_r) > s_atk)
                        : (level(smp_l) > s_atk || level(smp_r) > s_atk);
            rh = (level(smp_l) > s_rec) || (level(smp_r) > s_rec);
            lo = (s_gl < s_gr) ? s_gl : s_gr;
            if (!alc_en || clr_wr) begin
                m_st = alc_en ? 1 : 0;
                m_off = 0; m_lim = 0; m_lock = 0; m_dirty = 0;
            end else if (m_st == 0) begin
                m_st = 1;
            end else if (smp_vld) begin
                if (m_st == 2) begin
                    if (m_left == 1) begin
                        if ((s_mode == 1 || s_mode == 2) && m_off != 0 && !m_lock) begin
                            m_st = 3; m_left = 1 << s_rt; m_dirty = 0;
                        end else begin
                            m_st = 1;
                        end
                    end else begin
                        m_left--;
                    end
                end else if (ah) begin
                    if (m_off < lo) m_off++;
                    m_lim = 0; m_lock = 0; m_left = 1 << s_at; m_st = 2;
                end else if (m_st == 3) begin
                    if (m_left == 1) begin
                        d = m_dirty | rh;
                        m_dirty = 0; m_left = 1 << s_rt;
                        if (!d) begin
                            m_off--;
                            if (m_off == 0) m_st = 1;
                        end else if (s_mode == 2) begin
                            m_lim++;
                            if (m_lim >= s_lim) begin m_lock = 1; m_st = 1; end
                        end
                    end else begin
                        m_left--;
                        m_dirty = m_dirty | rh;
                    end
                end
            end else if (m_st == 2 || m_st == 3) begin
                m_left = m_left;
            end
            if (!alc_en) begin
                s_gl = (init_gain_l > 48) ? 48 : int'(init_gain_l);
                s_gr = (init_gain_r > 48) ? 48 : int'(init_gain_r);
                s_atk = int'(atk_thr); s_rec = int'(rec_thr);
                s_at = int'(atk_time); s_rt = int'(rec_time);
                s_mode = int'(rec_mode); s_both = both_ch; s_lim = int'(lim_max);
            end
        end
    end

    // compare against the reference on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (int'(gain_l) != s_gl - m_off || int'(gain_r) != s_gr - m_off ||
                int'(offset) != m_off || attacking != (m_st == 2) ||
                recovering != (m_st == 3) || locked != m_lock) begin
                n_bad++;
                $display("FAIL %s: gl=%0d/%0d gr=%0d/%0d off=%0d/%0d atk=%0b/%0b rec=%0b/%0b lck=%0b/%0b",
                         phase, gain_l, s_gl - m_off, gain_r, s_gr - m_off, offset, m_off,
                         attacking, (m_st == 2), recovering, (m_st == 3), locked, m_lock);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [23:0] l, input logic [23:0] r);
        smp_vld = v; smp_l = l; smp_r = r;
        @(negedge clk);
    endtask

    task automatic steps(input int n, input logic [23:0] l, input logic [23:0] r);
        for (int i = 0; i < n; i++) step(1'b1, l, r);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, QUIET, QUIET);
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        phase = "R1";
        chk("R1 reset gain", int'(gain_l), 0);
        chk("R1 reset offset", int'(offset), 0);

        init_gain_l = 6'd20; init_gain_r = 6'd14;
        atk_thr = 24'h400000; rec_thr = 24'h100000;
        atk_time = 3'd1; rec_time = 3'd2; rec_mode = 2'b00; both_ch = 0; lim_max = 4'd2;
        idle(2);
        chk("R1 captured gain_l", int'(gain_l), 20);
        chk("R1 captured gain_r", int'(gain_r), 14);
        init_gain_l = 6'd60;
        idle(1);
        chk("R1 clamp", int'(gain_l), 48);
        init_gain_l = 6'd20;
        idle(1);

        phase = "R3";
        alc_en = 1; idle(1);
        steps(5, QUIET, QUIETN);
        chk("R3 quiet", int'(offset), 0);
        step(1, LOUD, QUIET);
        chk("R3 step", int'(offset), 1);
        chk("R3 attacking", int'(attacking), 1);
        chk("R11 gain_l", int'(gain_l), 19);
        chk("R11 gain_r", int'(gain_r), 13);
        steps(2, LOUD, LOUD);
        chk("R3 wait ignores", int'(offset), 1);
        step(1, LOUD, QUIET);
        chk("R3 second step", int'(offset), 2);

        phase = "R2";
        steps(2, QUIET, QUIET);
        step(1, QUIET, 24'h800000);
        chk("R2 most negative", int'(offset), 3);
        steps(2, QUIET, QUIET);
        step(1, 24'h400000, QUIET);
        chk("R2 equal not over", int'(offset), 3);

        phase = "R12";
        step(0, LOUD, LOUD); step(0, LOUD, LOUD);
        chk("R12 invalid ignored", int'(offset), 3);

        phase = "R6";
        steps(40, QUIET, QUIET);
        chk("R6 no recovery", int'(offset), 3);

        phase = "R9";
        init_gain_l = 6'd30; atk_thr = 24'h000010; rec_mode = 2'b01;
        idle(1);
        chk("R9 gain frozen", int'(gain_l), 17);
        steps(3, MID, MID);
        chk("R9 threshold frozen", int'(offset), 3);
        init_gain_l = 6'd20; atk_thr = 24'h400000; rec_mode = 2'b00;

        phase = "R10";
        clr_wr = 1; idle(1); clr_wr = 0;
        chk("R10 clear", int'(offset), 0);
        chk("R10 attacking", int'(attacking), 0);

        phase = "R6";
        step(1, LOUD, QUIET);
        alc_en = 0; idle(1);
        chk("R6 toggle clears", int'(offset), 0);

        phase = "R4";
        both_ch = 1; idle(1); alc_en = 1; idle(1);
        step(1, LOUD, QUIET);
        chk("R4 one channel", int'(offset), 0);
        step(1, QUIET, LOUDN);
        chk("R4 other channel", int'(offset), 0);
        step(1, LOUD, LOUDN);
        chk("R4 both channels", int'(offset), 1);

        phase = "R5";
        alc_en = 0; both_ch = 0; init_gain_r = 6'd2; atk_time = 3'd0; idle(1);
        alc_en = 1; idle(1);
        steps(20, LOUD, LOUD);
        chk("R5 saturate", int'(offset), 2);
        chk("R5 gain_r floor", int'(gain_r), 0);
        chk("R5 gain_l", int'(gain_l), 18);

        phase = "R6";
        alc_en = 0; init_gain_r = 6'd14; rec_mode = 2'b11; idle(1);
        alc_en = 1; idle(1);
        steps(4, LOUD, QUIET);
        steps(10, QUIET, QUIET);
        chk("R6 alt code", int'(offset), 2);
        chk("R6 not recovering", int'(recovering), 0);

        phase = "R7";
        alc_en = 0; rec_mode = 2'b01; rec_time = 3'd1; idle(1);
        alc_en = 1; idle(1);
        steps(4, LOUD, QUIET);
        chk("R7 attacked", int'(offset), 2);
        chk("R12 recovering", int'(recovering), 1);
        step(0, MID, MID); step(0, MID, MID); step(0, MID, MID);
        steps(2, QUIET, QUIETN);
        chk("R7 one step back", int'(offset), 1);
        step(1, QUIET, MID); step(1, QUIET, QUIET);
        chk("R7 held", int'(offset), 1);
        steps(2, QUIET, QUIET);
        chk("R7 restored", int'(offset), 0);
        chk("R7 stop", int'(recovering), 0);
        steps(4, QUIET, QUIET);
        chk("R7 stays", int'(offset), 0);

        phase = "R8";
        alc_en = 0; rec_mode = 2'b10; lim_max = 4'd2; idle(1);
        alc_en = 1; idle(1);
        steps(4, LOUD, QUIET);
        steps(2, MID, QUIET);
        chk("R8 not yet", int'(locked), 0);
        steps(2, QUIET, MID);
        chk("R8 locked", int'(locked), 1);
        chk("R8 offset", int'(offset), 2);
        steps(10, QUIET, QUIET);
        chk("R8 no recovery", int'(offset), 2);
        step(1, LOUD, QUIET);
        chk("R8 attack step", int'(offset), 3);
        chk("R8 unlock", int'(locked), 0);
        steps(4, QUIET, QUIET);
        chk("R8 recovers again", int'(offset), 2);

        idle(2);
        finish_run();
    end

endmodule